// File: doc/BRIEF.md
# Seven-Port Locking Switch Allocator and Turn-Restricted Crossbar

This block performs switch allocation and switch traversal for a router in a three-dimensional mesh. Every input offers a flit with a request, a begin-of-packet marker, an end-of-packet marker, a 2-bit priority and a 3-bit target port code. One arbiter per output chooses among the head flits that target it. The winner keeps the output until the end-of-packet flit of its packet has crossed. Body flits then follow the locked path whatever their target field holds.

The crossbar is deliberately incomplete, to match negative-first turn rules. The local output and the three positive-direction outputs can be fed from any input. The three negative-direction outputs can be fed only from the local input or from negative-direction inputs. A head flit that asks for a turn the crossbar cannot make is never granted, and it raises an error flag for its input.

Grant and output are combinational in the cycle in which a flit is presented. A flit counts as transferred on the next rising clock edge when its request and grant are both high. An input that is not granted must keep its flit and request asserted.

Top module: `nf_switch_xbar`

## Requirements
- R1: After reset, no output is valid and no input is granted. The first equal-priority contest on an output is won by the lowest-numbered requesting input.
- R2: Port codes are 0 local, 1 +x, 2 +y, 3 +z, 4 -x, 5 -y, 6 -z, and code 7 names no port. A head flit (request and begin marker high) that targets a free output on a legal turn is granted in the same cycle. Its data, begin marker and end marker appear on that output with valid high.
- R3: When several head flits contend for a free output, the one with the highest numeric priority wins.
- R4: Among contenders of equal top priority, the winner is the first requester found when searching upward (with wrap-around) from the input after that output's previous winner.
- R5: Once a packet is granted on an output and its head flit is not also its last flit, that output carries only that input's flits, ignoring their target field. Other head flits for that output are not granted until the packet ends.
- R6: The cycle after the end-of-packet flit has crossed, the output is free and can be granted to another input. A single-flit packet (begin and end markers both high) never holds the output.
- R7: An output's round-robin position moves only when a new packet is granted, not on each body flit.
- R8: Outputs 4, 5 and 6 accept packets only from inputs 0, 4, 5 and 6. A head flit from input 1, 2 or 3 aimed at them is never granted and sets that input's error flag in the same cycle.
- R9: The valid of a locked output follows the owner's request. While the owner holds back, the output is not valid and the lock remains. An input's grant is high only while its request is high.
- R10: Packets bound for different outputs are granted and carried in the same cycle.
- R11: A head flit with target code 7 is never granted and sets its input's error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 7 | Per-input flit request (valid) |
| in_bop | input | 7 | Per-input begin-of-packet marker |
| in_eop | input | 7 | Per-input end-of-packet marker |
| in_dst | input | 21 | Per-input 3-bit target port code, input i at bits [3i+2:3i] |
| in_prio | input | 7*PRIO_W | Per-input packet priority |
| in_data | input | 7*FLIT_W | Per-input flit payload |
| in_gnt | output | 7 | Per-input grant; flit moves at the next edge when request and grant are high |
| in_err | output | 7 | Per-input illegal-target flag for a presented head flit |
| out_vld | output | 7 | Per-output flit valid |
| out_bop | output | 7 | Per-output begin-of-packet marker |
| out_eop | output | 7 | Per-output end-of-packet marker |
| out_data | output | 7*FLIT_W | Per-output flit payload |

## Verification
Locking and fresh arbitration meet when a held packet's body flit crosses an output while another input's higher-priority head flit is waiting for that same output. The waiting head must stay ungranted through the body flits, a stalled owner cycle and the end-of-packet flit, and it must win in the following cycle. Illegal-turn rejection and legal grants also fall in one cycle: a positive input and a negative input ask for the same negative output together. The bench then checks the grant vector, the error vector and the per-output flit scoreboard for that cycle.

// File: rtl/nf_xbar_pkg.sv
package nf_xbar_pkg;

   localparam int NPORT  = 7;
   localparam int PIDX_W = 3;

   typedef enum logic [PIDX_W-1:0] {
      PORT_LOCAL = 3'd0,
      PORT_XPOS  = 3'd1,
      PORT_YPOS  = 3'd2,
      PORT_ZPOS  = 3'd3,
      PORT_XNEG  = 3'd4,
      PORT_YNEG  = 3'd5,
      PORT_ZNEG  = 3'd6,
      PORT_NONE  = 3'd7
   } port_code_e;

   function automatic logic is_neg_port(input int p);
      return (p >= int'(PORT_XNEG)) && (p <= int'(PORT_ZNEG));
   endfunction

   // legal source -> destination pair for a negative-first crossbar
   function automatic logic turn_legal(input int src, input int dst);
      if (dst < 0 || dst >= NPORT) return 1'b0;
      if (is_neg_port(dst)) return (src == int'(PORT_LOCAL)) || is_neg_port(src);
      return 1'b1;
   endfunction

   function automatic logic [NPORT-1:0] src_mask_for(input int dst);
      logic [NPORT-1:0] m;
      for (int s = 0; s < NPORT; s++) m[s] = turn_legal(s, dst);
      return m;
   endfunction

endpackage

// File: rtl/nf_lock_arb.sv
module nf_lock_arb #(
   parameter int NREQ   = 7,
   parameter int PRIO_W = 2,
   parameter int IDX_W  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NREQ-1:0]          req_i,
   input  logic [NREQ*PRIO_W-1:0]   prio_i,
   input  logic                     fire_i,
   input  logic                     last_i,
   output logic                     sel_vld_o,
   output logic [IDX_W-1:0]         sel_idx_o,
   output logic                     busy_o
);

   localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(NREQ-1);

   logic                busy_q;
   logic [IDX_W-1:0]    owner_q;
   logic [IDX_W-1:0]    ptr_q;
   logic [PRIO_W-1:0]   best_p;
   logic [NREQ-1:0]     cand;
   logic                any_req;
   logic [IDX_W-1:0]    win_idx;

   // highest priority among requesters
   always_comb begin
      best_p = '0;
      for (int i = 0; i < NREQ; i++)
         if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_p))
            best_p = prio_i[i*PRIO_W +: PRIO_W];
   end

   always_comb begin
      for (int i = 0; i < NREQ; i++)
         cand[i] = req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] == best_p);
      any_req = |req_i;
   end

   // round-robin search starting after the previous winner
   always_comb begin
      logic found;
      found   = 1'b0;
      win_idx = '0;
      for (int k = 1; k <= NREQ; k++) begin
         int j;
         j = int'(ptr_q) + k;
         if (j >= NREQ) j = j - NREQ;
         if (!found && cand[j]) begin
            found   = 1'b1;
            win_idx = IDX_W'(j);
         end
      end
   end

   always_comb begin
      if (busy_q) begin
         sel_vld_o = 1'b1;
         sel_idx_o = owner_q;
      end else begin
         sel_vld_o = any_req;
         sel_idx_o = win_idx;
      end
   end

   assign busy_o = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         owner_q <= '0;
         ptr_q   <= PTR_RST;
      end else if (!busy_q) begin
         if (any_req) begin
            ptr_q   <= win_idx;
            owner_q <= win_idx;
            busy_q  <= !(fire_i && last_i);
         end
      end else if (fire_i && last_i) begin
         busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/nf_out_mux.sv
module nf_out_mux #(
   parameter int              NSRC       = 7,
   parameter int              FLIT_W     = 16,
   parameter int              IDX_W      = 3,
   parameter bit              RESTRICTED = 1'b0,
   parameter logic [NSRC-1:0] SRC_MASK   = '1
) (
   input  logic [NSRC*FLIT_W-1:0] data_i,
   input  logic [NSRC-1:0]        req_i,
   input  logic [NSRC-1:0]        bop_i,
   input  logic [NSRC-1:0]        eop_i,
   input  logic                   sel_vld_i,
   input  logic [IDX_W-1:0]       sel_idx_i,
   output logic [FLIT_W-1:0]      data_o,
   output logic                   vld_o,
   output logic                   bop_o,
   output logic                   eop_o
);

   logic path_ok;

   generate
      if (RESTRICTED) begin : g_restricted
         assign path_ok = sel_vld_i && SRC_MASK[sel_idx_i];
      end else begin : g_full
         assign path_ok = sel_vld_i;
      end
   endgenerate

   always_comb begin
      if (path_ok) begin
         data_o = data_i[sel_idx_i*FLIT_W +: FLIT_W];
         vld_o  = req_i[sel_idx_i];
         bop_o  = bop_i[sel_idx_i] && req_i[sel_idx_i];
         eop_o  = eop_i[sel_idx_i] && req_i[sel_idx_i];
      end else begin
         data_o = '0;
         vld_o  = 1'b0;
         bop_o  = 1'b0;
         eop_o  = 1'b0;
      end
   end

endmodule

// File: rtl/nf_switch_xbar.sv
module nf_switch_xbar
   import nf_xbar_pkg::*;
#(
   parameter int FLIT_W = 16,
   parameter int PRIO_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NPORT-1:0]          in_req,
   input  logic [NPORT-1:0]          in_bop,
   input  logic [NPORT-1:0]          in_eop,
   input  logic [NPORT*PIDX_W-1:0]   in_dst,
   input  logic [NPORT*PRIO_W-1:0]   in_prio,
   input  logic [NPORT*FLIT_W-1:0]   in_data,
   output logic [NPORT-1:0]          in_gnt,
   output logic [NPORT-1:0]          in_err,
   output logic [NPORT-1:0]          out_vld,
   output logic [NPORT-1:0]          out_bop,
   output logic [NPORT-1:0]          out_eop,
   output logic [NPORT*FLIT_W-1:0]   out_data
);

   generate
      if (FLIT_W < 1) begin : g_bad_flit_w
         $error("nf_switch_xbar: FLIT_W must be at least 1");
      end
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio_w
         $error("nf_switch_xbar: PRIO_W must lie in 1..8");
      end
   endgenerate

   logic [NPORT-1:0]        head;
   logic [NPORT-1:0]        sel_vld;
   logic [NPORT*PIDX_W-1:0] sel_idx;
   logic [NPORT-1:0]        busy;

   assign head = in_req & in_bop;

   genvar go, gi;
   generate
      for (go = 0; go < NPORT; go++) begin : g_out
         logic [NPORT-1:0]  req_vec;
         logic [PIDX_W-1:0] idx;
         logic              fire;
         logic              last;

         for (gi = 0; gi < NPORT; gi++) begin : g_src
            if (turn_legal(gi, go)) begin : g_legal
               assign req_vec[gi] = head[gi] && (in_dst[gi*PIDX_W +: PIDX_W] == PIDX_W'(go));
            end else begin : g_blocked
               assign req_vec[gi] = 1'b0;
            end
         end

         assign idx  = sel_idx[go*PIDX_W +: PIDX_W];
         assign fire = sel_vld[go] && in_req[idx];
         assign last = in_eop[idx];

         nf_lock_arb #(
            .NREQ   (NPORT),
            .PRIO_W (PRIO_W),
            .IDX_W  (PIDX_W)
         ) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req_vec),
            .prio_i    (in_prio),
            .fire_i    (fire),
            .last_i    (last),
            .sel_vld_o (sel_vld[go]),
            .sel_idx_o (sel_idx[go*PIDX_W +: PIDX_W]),
            .busy_o    (busy[go])
         );

         nf_out_mux #(
            .NSRC       (NPORT),
            .FLIT_W     (FLIT_W),
            .IDX_W      (PIDX_W),
            .RESTRICTED (is_neg_port(go)),
            .SRC_MASK   (src_mask_for(go))
         ) u_mux (
            .data_i    (in_data),
            .req_i     (in_req),
            .bop_i     (in_bop),
            .eop_i     (in_eop),
            .sel_vld_i (sel_vld[go]),
            .sel_idx_i (idx),
            .data_o    (out_data[go*FLIT_W +: FLIT_W]),
            .vld_o     (out_vld[go]),
            .bop_o     (out_bop[go]),
            .eop_o     (out_eop[go])
         );
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < NPORT; i++) begin
         logic owned;
         owned = 1'b0;
         for (int o = 0; o < NPORT; o++)
            if (sel_vld[o] && (sel_idx[o*PIDX_W +: PIDX_W] == PIDX_W'(i)))
               owned = 1'b1;
         in_gnt[i] = in_req[i] && owned;
         in_err[i] = head[i] && !turn_legal(i, int'(in_dst[i*PIDX_W +: PIDX_W]));
      end
   end

endmodule

// File: rtl/nf_xbar_chk.sv
module nf_xbar_chk
   import nf_xbar_pkg::*;
(
   input logic                      clk,
   input logic                      rst_n,
   input logic [NPORT-1:0]          in_req,
   input logic [NPORT-1:0]          in_gnt,
   input logic [NPORT-1:0]          in_err,
   input logic [NPORT-1:0]          out_vld,
   input logic [NPORT-1:0]          out_eop,
   input logic [NPORT-1:0]          sel_vld,
   input logic [NPORT*PIDX_W-1:0]   sel_idx,
   input logic [NPORT-1:0]          busy
);

   p_gnt_vld_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_gnt) == $countones(out_vld));

   genvar gi, go;
   generate
      for (gi = 0; gi < NPORT; gi++) begin : g_in
         p_err_no_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
            in_err[gi] |-> !in_gnt[gi]);
         p_gnt_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_gnt[gi] |-> in_req[gi]);
      end

      for (go = 0; go < NPORT; go++) begin : g_out
         p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[go] && !out_eop[go]) |=>
               (sel_vld[go] && sel_idx[go*PIDX_W +: PIDX_W] == $past(sel_idx[go*PIDX_W +: PIDX_W])));
         p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[go] && out_eop[go]) |=> !busy[go]);
         p_stall_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[go] && !out_vld[go]) |=>
               (busy[go] && $stable(sel_idx[go*PIDX_W +: PIDX_W])));
         if (is_neg_port(go)) begin : g_neg
            p_neg_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
               sel_vld[go] |-> !(sel_idx[go*PIDX_W +: PIDX_W] inside {3'd1, 3'd2, 3'd3}));
         end
      end
   endgenerate

endmodule

bind nf_switch_xbar nf_xbar_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_req  (in_req),
   .in_gnt  (in_gnt),
   .in_err  (in_err),
   .out_vld (out_vld),
   .out_eop (out_eop),
   .sel_vld (sel_vld),
   .sel_idx (sel_idx),
   .busy    (busy)
);

// File: tb/tb_nf_switch_xbar.sv
`timescale 1ns/1ps
module tb_nf_switch_xbar;

   localparam int NP = 7;
   localparam int FW = 16;
   localparam int PW = 2;

   typedef struct packed {
      logic [FW-1:0] d;
      logic          b;
      logic          e;
   } flit_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NP-1:0]      b_req, b_bop, b_eop;
   logic [2:0]         b_dst  [NP];
   logic [PW-1:0]      b_prio [NP];
   logic [FW-1:0]      b_data [NP];

   logic [NP*3-1:0]    in_dst;
   logic [NP*PW-1:0]   in_prio;
   logic [NP*FW-1:0]   in_data;
   logic [NP-1:0]      in_gnt, in_err, out_vld, out_bop, out_eop;
   logic [NP*FW-1:0]   out_data;

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         in_dst[i*3 +: 3]    = b_dst[i];
         in_prio[i*PW +: PW] = b_prio[i];
         in_data[i*FW +: FW] = b_data[i];
      end
   end

   nf_switch_xbar #(.FLIT_W(FW), .PRIO_W(PW)) dut (
      .clk(clk), .rst_n(rst_n),
      .in_req(b_req), .in_bop(b_bop), .in_eop(b_eop),
      .in_dst(in_dst), .in_prio(in_prio), .in_data(in_data),
      .in_gnt(in_gnt), .in_err(in_err),
      .out_vld(out_vld), .out_bop(out_bop), .out_eop(out_eop), .out_data(out_data)
   );

   int checks = 0;
   int errors = 0;
   flit_t exp_q [NP][$];
   bit finished = 1'b0;

   task automatic chk_vec(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic chk_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle_all();
      b_req = '0; b_bop = '0; b_eop = '0;
      for (int i = 0; i < NP; i++) begin
         b_dst[i] = 3'd0; b_prio[i] = '0; b_data[i] = '0;
      end
   endtask

   task automatic drive(int i, bit bop, bit eop, int dst, int pr, logic [FW-1:0] d);
      b_req[i] = 1'b1; b_bop[i] = bop; b_eop[i] = eop;
      b_dst[i] = 3'(dst); b_prio[i] = PW'(pr); b_data[i] = d;
   endtask

   task automatic expect_flit(int o, logic [FW-1:0] d, bit bop, bit eop);
      flit_t f;
      f.d = d; f.b = bop; f.e = eop;
      exp_q[o].push_back(f);
   endtask

   task automatic advance();
      @(posedge clk); #1;
      idle_all();
   endtask

   // scoreboard monitor: every valid output flit must match the next expected item
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int o = 0; o < NP; o++) begin
            if (out_vld[o]) begin
               checks++;
               if (exp_q[o].size() == 0) begin
                  errors++;
                  $display("FAIL R2 out%0d: actual unexpected flit %h expected none", o,
                           out_data[o*FW +: FW]);
               end else begin
                  flit_t want, got;
                  want = exp_q[o].pop_front();
                  got.d = out_data[o*FW +: FW]; got.b = out_bop[o]; got.e = out_eop[o];
                  if (got !== want) begin
                     errors++;
                     $display("FAIL R2 out%0d: actual %h/%b/%b expected %h/%b/%b", o,
                              got.d, got.b, got.e, want.d, want.b, want.e);
                  end
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_all();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: idle after reset
      @(negedge clk);
      chk_vec("R1 out_vld after reset", out_vld, 7'b0);
      chk_vec("R1 gnt after reset", in_gnt, 7'b0);
      advance();

      // R2 / R10: three packets to three outputs in one cycle
      drive(1, 1, 1, 0, 0, 16'h1100); expect_flit(0, 16'h1100, 1, 1);
      drive(4, 1, 1, 6, 0, 16'h4406); expect_flit(6, 16'h4406, 1, 1);
      drive(0, 1, 1, 2, 0, 16'h0002); expect_flit(2, 16'h0002, 1, 1);
      @(negedge clk);
      chk_vec("R10 parallel grants", in_gnt, 7'b0010011);
      chk_vec("R2 no error", in_err, 7'b0);
      advance();

      // R1: first tie on output 3 goes to the lower input
      drive(2, 1, 1, 3, 0, 16'h2203); drive(5, 1, 1, 3, 0, 16'h5503);
      expect_flit(3, 16'h2203, 1, 1);
      @(negedge clk);
      chk_vec("R1 first tie winner", in_gnt, 7'b0000100);
      advance();

      // R4: round robin moves on
      drive(2, 1, 1, 3, 0, 16'h2213); drive(5, 1, 1, 3, 0, 16'h5513);
      expect_flit(3, 16'h5513, 1, 1);
      @(negedge clk);
      chk_vec("R4 rr second", in_gnt, 7'b0100000);
      advance();
      drive(2, 1, 1, 3, 0, 16'h2223); drive(5, 1, 1, 3, 0, 16'h5523);
      expect_flit(3, 16'h2223, 1, 1);
      @(negedge clk);
      chk_vec("R4 rr wrap", in_gnt, 7'b0000100);
      advance();

      // R3: priority beats round-robin order
      drive(6, 1, 1, 1, 3, 16'h6601); drive(0, 1, 1, 1, 1, 16'h0001);
      expect_flit(1, 16'h6601, 1, 1);
      @(negedge clk);
      chk_vec("R3 high prio wins", in_gnt, 7'b1000000);
      advance();

      // R5 / R9 / R6: locked packet on output 2 against a waiting high-priority head
      drive(3, 1, 0, 2, 0, 16'h3300); expect_flit(2, 16'h3300, 1, 0);
      @(negedge clk);
      chk_vec("R5 head granted", in_gnt, 7'b0001000);
      advance();
      drive(3, 0, 0, 5, 0, 16'h3301); expect_flit(2, 16'h3301, 0, 0);
      drive(1, 1, 1, 2, 3, 16'h1102);
      @(negedge clk);
      chk_vec("R5 body keeps lock", in_gnt, 7'b0001000);
      advance();
      drive(1, 1, 1, 2, 3, 16'h1102);
      @(negedge clk);
      chk_vec("R9 owner stall no valid", out_vld, 7'b0);
      chk_vec("R9 owner stall no grant", in_gnt, 7'b0);
      advance();
      drive(3, 0, 1, 0, 0, 16'h3302); expect_flit(2, 16'h3302, 0, 1);
      drive(1, 1, 1, 2, 3, 16'h1102);
      @(negedge clk);
      chk_vec("R5 tail granted", in_gnt, 7'b0001000);
      advance();
      drive(1, 1, 1, 2, 3, 16'h1102); expect_flit(2, 16'h1102, 1, 1);
      @(negedge clk);
      chk_vec("R6 freed after tail", in_gnt, 7'b0000010);
      advance();

      // R7: three-flit packet on output 5 advances the pointer once
      drive(4, 1, 0, 5, 0, 16'h4500); expect_flit(5, 16'h4500, 1, 0);
      advance();
      drive(4, 0, 0, 0, 0, 16'h4501); expect_flit(5, 16'h4501, 0, 0);
      advance();
      drive(4, 0, 1, 0, 0, 16'h4502); expect_flit(5, 16'h4502, 0, 1);
      advance();
      drive(0, 1, 1, 5, 0, 16'h0005); drive(5, 1, 1, 5, 0, 16'h5505);
      expect_flit(5, 16'h5505, 1, 1);
      @(negedge clk);
      chk_vec("R7 pointer per packet", in_gnt, 7'b0100000);
      advance();

      // R8: illegal turns rejected while a legal contender wins
      drive(2, 1, 1, 4, 3, 16'h2204); drive(5, 1, 1, 4, 0, 16'h5504);
      drive(3, 1, 1, 6, 0, 16'h3306);
      expect_flit(4, 16'h5504, 1, 1);
      @(negedge clk);
      chk_vec("R8 only legal granted", in_gnt, 7'b0100000);
      chk_vec("R8 error flags", in_err, 7'b0001100);
      chk_vec("R8 outputs", out_vld, 7'b0010000);
      advance();
      drive(0, 1, 1, 5, 0, 16'h0015); drive(6, 1, 1, 4, 0, 16'h6604);
      expect_flit(5, 16'h0015, 1, 1); expect_flit(4, 16'h6604, 1, 1);
      @(negedge clk);
      chk_vec("R8 local and negative sources", in_gnt, 7'b1000001);
      advance();

      // R11: target code 7
      drive(1, 1, 1, 7, 0, 16'h1107);
      @(negedge clk);
      chk_vec("R11 no grant", in_gnt, 7'b0);
      chk_vec("R11 error flag", in_err, 7'b0000010);
      advance();

      repeat (2) @(negedge clk);
      for (int o = 0; o < NP; o++)
         chk_int($sformatf("R2 out%0d pending flits", o), exp_q[o].size(), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule